// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flagged Receive Queue

This block turns an asynchronous serial line into a queue of received bytes. An enable pulse arrives at sixteen times the bit rate. The receiver finds the falling edge that opens a frame and samples every bit in the middle of its bit cell. It then checks the stop bit and, when parity is enabled, the parity bit. A line that stays low past the end of a frame is reported as a break.

Each finished frame goes into a sixteen-deep queue. Every entry holds the byte and four error flags: overrun, break, parity and framing. The host sees the oldest entry at the head of the queue and removes it with a one-cycle read strobe. Empty and full indications show the state of the queue. A sticky error register gathers every flag raised since it was last cleared, and a one-cycle clear strobe empties it.

Top module: `serial_rx_errfifo`

## Requirements
- R1: After reset, `rx_empty` is 1, `rx_full` is 0 and `err_sticky` is 0.
- R2: A falling edge on `rx_line` while the receiver is idle starts a frame. The start bit is sampled 8 oversample ticks after the edge, and each later bit 16 ticks after the one before. Data arrives least significant bit first, and a frame with a high stop bit is stored with all four flags 0.
- R3: If the start bit reads high at its mid-bit sample, the edge is treated as a glitch. Nothing is stored, and the receiver waits for the next falling edge.
- R4: A frame whose stop bit samples low, and which is not a break, is stored with its received byte and `rd_fe` set to 1.
- R5: When `par_en` is 1, a parity bit follows bit 7 and comes before the stop bit. The value expected is the XOR of the data bits, inverted when `par_odd` is 1. A mismatch sets `rd_pe` for that entry.
- R6: If every bit up to and including the stop bit samples low, and the line is still low one bit time after the stop sample, exactly one entry is stored: data 0, `rd_be`=1, `rd_fe`=1, `rd_pe`=0. No new frame starts until the line has returned high.
- R7: Entries leave the queue in arrival order. `rx_full` is 1 exactly when 16 entries are held.
- R8: A frame that completes while 16 entries are held is discarded. `rd_oe` is set on the next entry that is stored.
- R9: `rx_empty` falls once an entry is held. A `rd_en` pulse removes the head entry, and `rx_empty` rises again when the last entry is removed.
- R10: `err_sticky` bits are, from bit 3 down to bit 0: overrun, break, parity, framing. Each bit is set when that condition occurs, and all of them clear on an `err_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| os_tick | input | 1 | Oversample enable, 16 per bit |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| par_en | input | 1 | Enables the parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_en | input | 1 | Removes the head entry |
| rd_byte | output | 8 | Data of the head entry |
| rd_oe | output | 1 | Overrun flag of the head entry |
| rd_be | output | 1 | Break flag of the head entry |
| rd_pe | output | 1 | Parity flag of the head entry |
| rd_fe | output | 1 | Framing flag of the head entry |
| rx_empty | output | 1 | Queue holds no entry |
| rx_full | output | 1 | Queue holds 16 entries |
| err_sticky | output | 4 | Accumulated flags {oe, be, pe, fe} |
| err_clr | input | 1 | Clears `err_sticky` |

## Verification
The hardest state to reach is an overrun that later shows up on a stored entry. To get there, the queue is filled with sixteen frames without any reads, and a seventeenth frame is sent into the full queue. One entry is then read out and another frame is sent, so the overrun flag must land on that entry rather than on an older one. Break needs the line held low well past a frame. Glitch rejection needs a low pulse shorter than half a bit, followed by a normal frame to confirm that the receiver recovered.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK,
        ST_WAITHI
    } rx_state_e;

    typedef struct packed {
        logic oe;
        logic be;
        logic pe;
        logic fe;
    } rx_flags_t;

    localparam int FLAG_W = 4;

endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q, chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxq_framer.sv
module rxq_framer
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              line_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    output logic              push_o,
    output logic [DATA_W-1:0] data_o,
    output rx_flags_t         flags_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OSR / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              allz;
        logic              pe;
        logic              prev;
        logic              push;
        logic [DATA_W-1:0] dout;
        rx_flags_t         fl;
    } fr_t;

    fr_t q, d;
    logic at_bit, at_half;

    always_comb begin
        at_bit  = tick_i && (q.cnt == CNT_LAST);
        at_half = tick_i && (q.cnt == CNT_HALF);
        d       = q;
        d.push  = 1'b0;
        if (tick_i) d.prev = line_i;
        case (q.st)
            ST_IDLE: begin
                if (tick_i && q.prev && !line_i) begin
                    d.st  = ST_START;
                    d.cnt = '0;
                end
            end
            ST_START: begin
                if (at_half) begin
                    d.cnt = '0;
                    if (line_i) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.st   = ST_DATA;
                        d.idx  = '0;
                        d.allz = 1'b1;
                        d.pe   = 1'b0;
                    end
                end else if (tick_i) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_DATA: begin
                if (at_bit) begin
                    d.cnt  = '0;
                    d.sh   = {line_i, q.sh[DATA_W-1:1]};
                    d.allz = q.allz & ~line_i;
                    if (q.idx == IDX_LAST) d.st = par_en_i ? ST_PAR : ST_STOP;
                    else                   d.idx = q.idx + 1'b1;
                end else if (tick_i) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_PAR: begin
                if (at_bit) begin
                    d.cnt  = '0;
                    d.pe   = (^q.sh) ^ line_i ^ par_odd_i;
                    d.allz = q.allz & ~line_i;
                    d.st   = ST_STOP;
                end else if (tick_i) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_STOP: begin
                if (at_bit) begin
                    d.cnt = '0;
                    if (!line_i && q.allz) begin
                        d.st = ST_BRK;
                    end else begin
                        d.st   = ST_IDLE;
                        d.push = 1'b1;
                        d.dout = q.sh;
                        d.fl   = '{oe: 1'b0, be: 1'b0, pe: q.pe, fe: ~line_i};
                    end
                end else if (tick_i) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_BRK: begin
                if (at_bit) begin
                    d.cnt  = '0;
                    d.push = 1'b1;
                    d.dout = '0;
                    if (!line_i) begin
                        d.st = ST_WAITHI;
                        d.fl = '{oe: 1'b0, be: 1'b1, pe: 1'b0, fe: 1'b1};
                    end else begin
                        d.st = ST_IDLE;
                        d.fl = '{oe: 1'b0, be: 1'b0, pe: q.pe, fe: 1'b1};
                    end
                end else if (tick_i) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WAITHI: begin
                if (tick_i && line_i) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign push_o  = q.push;
    assign data_o  = q.dout;
    assign flags_o = q.fl;

    AST_GLITCH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_START && at_half && line_i) |=> (q.st == ST_IDLE && !push_o)); // R3
    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o); // R2
    AST_BREAK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && flags_o.be) |-> (flags_o.fe && data_o == '0 && !flags_o.pe)); // R6
    AST_WAITHI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAITHI && !line_i) |=> (q.st == ST_WAITHI)); // R6
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t q, d;
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        d = q;
        if (wr_i) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        if (rd_i) d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        case ({wr_i, rd_i})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_i) mem_q[q.wp] <= wdata_i;
    end

    assign rdata_o = mem_q[q.rp];
    assign empty_o = (q.cnt == '0);
    assign full_o  = (q.cnt == CNT_FULL);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_FULL); // R7
    AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |-> !empty_o); // R9
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i) |=> (q.cnt == $past(q.cnt) - 1'b1)); // R9
endmodule

// File: rtl/serial_rx_errfifo.sv
module serial_rx_errfifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_line,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rd_oe,
    output logic              rd_be,
    output logic              rd_pe,
    output logic              rd_fe,
    output logic              rx_empty,
    output logic              rx_full,
    output logic [3:0]        err_sticky,
    input  logic              err_clr
);
    localparam int ENTRY_W = DATA_W + FLAG_W;

    typedef struct packed {
        logic       oe_pend;
        logic [3:0] sticky;
    } top_t;

    top_t q, d;

    logic              line_s;
    logic              f_push;
    logic [DATA_W-1:0] f_data;
    rx_flags_t         f_flags;
    logic              q_wr, q_rd, q_empty, q_full, drop;
    logic [ENTRY_W-1:0] wentry, rentry;
    logic [3:0]        new_bits;

    rxq_sync #(.STAGES(2), .RESET_VAL(1'b1)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_i(rx_line), .sync_o(line_s)
    );

    rxq_framer #(.DATA_W(DATA_W), .OSR(OSR)) i_framer (
        .clk(clk), .rst_n(rst_n), .tick_i(os_tick), .line_i(line_s),
        .par_en_i(par_en), .par_odd_i(par_odd),
        .push_o(f_push), .data_o(f_data), .flags_o(f_flags)
    );

    always_comb begin
        q_rd     = rd_en && !q_empty;
        q_wr     = f_push && (!q_full || q_rd);
        drop     = f_push && !q_wr;
        wentry   = {q.oe_pend, f_flags.be, f_flags.pe, f_flags.fe, f_data};
        new_bits = f_push ? {drop, f_flags.be, f_flags.pe, f_flags.fe} : 4'b0000;
        d         = q;
        if (drop)      d.oe_pend = 1'b1;
        else if (q_wr) d.oe_pend = 1'b0;
        d.sticky  = (err_clr ? 4'b0000 : q.sticky) | new_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    rxq_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .wr_i(q_wr), .wdata_i(wentry),
        .rd_i(q_rd), .rdata_o(rentry), .empty_o(q_empty), .full_o(q_full)
    );

    assign rd_byte    = rentry[DATA_W-1:0];
    assign rd_fe      = rentry[DATA_W];
    assign rd_pe      = rentry[DATA_W+1];
    assign rd_be      = rentry[DATA_W+2];
    assign rd_oe      = rentry[DATA_W+3];
    assign rx_empty   = q_empty;
    assign rx_full    = q_full;
    assign err_sticky = q.sticky;

    AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> (rx_full && !rd_en)); // R8
    AST_DROP_MARKS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (q.oe_pend && err_sticky[3])); // R8
    AST_STICKY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !f_push) |=> (err_sticky == 4'b0000)); // R10
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full && rx_empty)); // R7
endmodule

// File: tb/test_serial_rx_errfifo.sv
module test_serial_rx_errfifo;
    localparam int BIT = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0;
    logic rx_line = 1'b1;
    logic par_en = 1'b0;
    logic par_odd = 1'b0;
    logic rd_en = 1'b0;
    logic err_clr = 1'b0;
    logic [7:0] rd_byte;
    logic rd_oe, rd_be, rd_pe, rd_fe, rx_empty, rx_full;
    logic [3:0] err_sticky;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_rx_errfifo i_serial_rx_errfifo (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .par_en(par_en), .par_odd(par_odd), .rd_en(rd_en),
        .rd_byte(rd_byte), .rd_oe(rd_oe), .rd_be(rd_be), .rd_pe(rd_pe),
        .rd_fe(rd_fe), .rx_empty(rx_empty), .rx_full(rx_full),
        .err_sticky(err_sticky), .err_clr(err_clr)
    );

    initial begin
        forever begin
            @(negedge clk);
            os_tick = ~os_tick;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int cycles);
        @(negedge clk);
        rx_line = v;
        repeat (cycles - 1) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] dv, input bit use_par, input logic pbit,
                        input logic stopv);
        hold(1'b0, BIT);
        for (int i = 0; i < 8; i++) hold(dv[i], BIT);
        if (use_par) hold(pbit, BIT);
        hold(stopv, BIT);
        hold(1'b1, BIT);
    endtask

    task automatic pop_chk(input string req, input logic [7:0] ed, input logic eoe,
                           input logic ebe, input logic epe, input logic efe);
        @(negedge clk);
        chk(!rx_empty, {req, " entry present"}, rx_empty, 0);
        chk(rd_byte == ed, {req, " data"}, rd_byte, ed);
        chk({rd_oe, rd_be, rd_pe, rd_fe} == {eoe, ebe, epe, efe}, {req, " flags"},
            {rd_oe, rd_be, rd_pe, rd_fe}, {eoe, ebe, epe, efe});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear_sticky();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(rx_empty == 1'b1, "R1 empty", rx_empty, 1);
        chk(rx_full == 1'b0, "R1 full", rx_full, 0);
        chk(err_sticky == 4'b0, "R1 sticky", err_sticky, 0);
        hold(1'b1, 2 * BIT);

        // R2 / R9 sweep over every byte value
        for (int v = 0; v < 256; v++) begin
            send(8'(v), 1'b0, 1'b0, 1'b1);
            pop_chk("R2", 8'(v), 0, 0, 0, 0);
            @(negedge clk);
            chk(rx_empty == 1'b1, "R9 empty after pop", rx_empty, 1);
        end
        chk(err_sticky == 4'b0, "R10 no flags on clean frames", err_sticky, 0);

        // R3 short low pulse ignored, then receiver recovers
        hold(1'b0, 6);
        hold(1'b1, 2 * BIT);
        chk(rx_empty == 1'b1, "R3 glitch stored nothing", rx_empty, 1);
        send(8'hC3, 1'b0, 1'b0, 1'b1);
        pop_chk("R3 recovery", 8'hC3, 0, 0, 0, 0);

        // R4 framing error keeps data
        send(8'h5A, 1'b0, 1'b0, 1'b0);
        pop_chk("R4", 8'h5A, 0, 0, 0, 1);
        chk(err_sticky == 4'b0001, "R10 sticky fe", err_sticky, 1);
        clear_sticky();
        @(negedge clk);
        chk(err_sticky == 4'b0000, "R10 cleared", err_sticky, 0);

        // R5 parity, both senses, correct and wrong bits
        par_en = 1'b1;
        for (int m = 0; m < 2; m++) begin
            par_odd = m[0];
            for (int k = 0; k < 4; k++) begin
                logic [7:0] dv;
                logic good;
                dv   = 8'(37 * k + 11 * m + 1);
                good = (^dv) ^ m[0];
                send(dv, 1'b1, good, 1'b1);
                pop_chk("R5 good parity", dv, 0, 0, 0, 0);
                send(dv, 1'b1, ~good, 1'b1);
                pop_chk("R5 bad parity", dv, 0, 0, 1, 0);
            end
        end
        chk(err_sticky == 4'b0010, "R10 sticky pe", err_sticky, 2);
        par_en = 1'b0;
        par_odd = 1'b0;
        clear_sticky();

        // R6 break
        hold(1'b0, 14 * BIT);
        hold(1'b1, 2 * BIT);
        pop_chk("R6 break", 8'h00, 0, 1, 0, 1);
        @(negedge clk);
        chk(rx_empty == 1'b1, "R6 single entry", rx_empty, 1);
        chk(err_sticky == 4'b0101, "R10 sticky be fe", err_sticky, 5);
        clear_sticky();

        // R7 / R8 fill, overrun, oe on next stored entry
        for (int i = 0; i < 16; i++) begin
            send(8'(8'h30 + i), 1'b0, 1'b0, 1'b1);
            @(negedge clk);
            chk(rx_full == (i == 15), "R7 full flag", rx_full, (i == 15));
        end
        send(8'hEE, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk(err_sticky == 4'b1000, "R8 sticky oe", err_sticky, 8);
        pop_chk("R7 order", 8'h30, 0, 0, 0, 0);
        send(8'h77, 1'b0, 1'b0, 1'b1);
        for (int i = 1; i < 16; i++) pop_chk("R7 order", 8'(8'h30 + i), 0, 0, 0, 0);
        pop_chk("R8 oe on next stored", 8'h77, 1, 0, 0, 0);
        @(negedge clk);
        chk(rx_empty == 1'b1, "R8 dropped frame absent", rx_empty, 1);
        clear_sticky();
        @(negedge clk);
        chk(err_sticky == 4'b0000, "R10 cleared after oe", err_sticky, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule